// File: doc/BRIEF.md
# Receive Byte Queue with Sticky Status

This block sits between the receive side of a serial peripheral and the host that drains it. The serial side pushes each received byte into a small first-in first-out store. The host, either a processor or a DMA engine, pops bytes out. A small register port gives the host the queue's live state, its latched error history and the controls for a service request.

Full and empty are reported as live conditions. Underflow (a pop while the store is empty), overflow (a push while it is full) and a summary error bit are latched. They stay set until the host writes a 1 to them. A pop on an empty queue or a push on a full queue moves no pointer, so the queue contents are never corrupted. The service request (`alarm_o`) rises when the occupancy reaches a programmable level. It then stays high until the occupancy drains down to a separate, smaller leftover amount, which gives the request hysteresis. A frame-mode control bit comes out of reset set. While it is set, service requests are held off, so software must clear it before use.

The register port has four word addresses, each 16 bits wide:
- 0: status
- 1: control
- 2: request level
- 3: occupancy count

Reads are combinational. Writes take effect at the clock edge.

Top module: `rx_byte_queue`

## Requirements
- R1: Bytes are returned in the order they were accepted. A pop with `rd_en` on a non-empty queue presents the oldest byte on `rd_data` from the clock edge that accepts the pop.
- R2: Status bit 0 (empty) and status bit 2 (full) are live. They match `empty_o` and `full_o`, and address 3 returns the occupancy, from 0 to 16.
- R3: A push while full is dropped and leaves the occupancy unchanged. It sets the sticky overflow flag, status bit 4.
- R4: A pop while empty leaves `rd_data` and the occupancy unchanged. It sets the sticky underflow flag, status bit 5.
- R5: The summary error flag, status bit 6, sets with any overflow or underflow event.
- R6: Writing status with a 1 in bit 4, 5 or 6 clears only that flag. Zeros in those bits, and any value in bits 0 to 2, change nothing.
- R7: After reset, control reads 0x0009 and the request level reads 0. In control, bits 2:0 hold the release amount and bit 3 is frame enable.
- R8: While control bit 3 is 1, `alarm_o` and status bit 1 stay 0.
- R9: With frame enable at 0, the request is raised one cycle after the occupancy is both at or above the level and above the release amount.
- R10: Once raised, the request stays high until the occupancy is at or below the release amount. It drops one cycle later.
- R11: Reserved bits read 0. This covers status bits 3 and 15:7, control bits 15:4, level bits 15:5 and count bits 15:5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Push request from the serial receiver |
| wr_data | input | 8 | Byte to push |
| rd_en | input | 1 | Pop request from the host |
| rd_data | output | 8 | Last popped byte |
| reg_addr | input | 2 | Register word address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| full_o | output | 1 | Live full indication |
| empty_o | output | 1 | Live empty indication |
| alarm_o | output | 1 | Service request |

## Verification
The bench builds the block with its default parameters: a depth of 16 and an 8-bit width. At these values the full boundary and the push-while-full case are reached in a handful of cycles. A 5-bit count covers the whole 0 to 16 range, including the value 16 itself. The 3-bit release field is wide enough to separate the raise level (5) from the release amount (2). This lets the bench observe the hysteresis band at counts 3 and 4, where the request must stay high.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int REG_W = 16;

  typedef enum logic [1:0] {
    RA_STATUS = 2'd0,
    RA_CTRL   = 2'd1,
    RA_LEVEL  = 2'd2,
    RA_COUNT  = 2'd3
  } rxq_addr_e;

  localparam int ST_EMPTY = 0;
  localparam int ST_ALARM = 1;
  localparam int ST_FULL  = 2;
  localparam int ST_OVF   = 4;
  localparam int ST_UDF   = 5;
  localparam int ST_ERR   = 6;

  localparam int GRAN_W   = 3;
  localparam int CT_FRAME = 3;

  typedef struct packed {
    logic ovf;
    logic udf;
    logic oob;
  } rxq_events_t;
endpackage

// File: rtl/rxq_storage.sv
module rxq_storage
  import rxq_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop_req,
  output logic [WIDTH-1:0] pop_data,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty,
  output rxq_events_t      events
);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [WIDTH-1:0] dout_q, dout_d;
  logic             push_ok, pop_ok;
  logic             oob;

  assign full    = (cnt_q == CNT_MAX);
  assign empty   = (cnt_q == '0);
  assign push_ok = push_req & ~full;
  assign pop_ok  = pop_req & ~empty;

  generate
    if ((1 << PTR_W) == DEPTH) begin : g_pow2
      assign oob = 1'b0;
    end else begin : g_npow2
      assign oob = (wr_ptr_q > LAST_IDX) | (rd_ptr_q > LAST_IDX);
    end
  endgenerate

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    dout_d   = dout_q;
    if (push_ok) begin
      wr_ptr_d = (wr_ptr_q == LAST_IDX) ? '0 : wr_ptr_q + 1'b1;
    end
    if (pop_ok) begin
      rd_ptr_d = (rd_ptr_q == LAST_IDX) ? '0 : rd_ptr_q + 1'b1;
      dout_d   = mem_q[rd_ptr_q];
    end
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      mem_q[wr_ptr_q] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      dout_q   <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
      dout_q   <= dout_d;
    end
  end

  assign pop_data   = dout_q;
  assign count      = cnt_q;
  assign events.ovf = push_req & full;
  assign events.udf = pop_req & empty;
  assign events.oob = oob;

  // R2
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  // R3
  full_push_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_req && !pop_req) |=> (cnt_q == $past(cnt_q)));

  // R4
  empty_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop_req) |=> $stable(dout_q));
endmodule

// File: rtl/rxq_flags.sv
module rxq_flags
  import rxq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  rxq_events_t events,
  input  logic        clr_ovf,
  input  logic        clr_udf,
  input  logic        clr_err,
  output logic        ovf,
  output logic        udf,
  output logic        err
);
  logic ovf_q, ovf_d;
  logic udf_q, udf_d;
  logic err_q, err_d;

  always_comb begin
    ovf_d = events.ovf | (ovf_q & ~clr_ovf);
    udf_d = events.udf | (udf_q & ~clr_udf);
    err_d = events.ovf | events.udf | events.oob | (err_q & ~clr_err);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      udf_q <= udf_d;
      err_q <= err_d;
    end
  end

  assign ovf = ovf_q;
  assign udf = udf_q;
  assign err = err_q;

  // R3
  ovf_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    events.ovf |=> ovf_q);

  // R5
  err_on_udf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    events.udf |=> err_q);
endmodule

// File: rtl/rxq_alarm.sv
module rxq_alarm
  import rxq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  level,
  input  logic [GRAN_W-1:0] gran,
  input  logic              frame_en,
  output logic              alarm
);
  logic             alarm_q, alarm_d;
  logic [CNT_W-1:0] gran_ext;
  logic             above_gran;

  assign gran_ext   = CNT_W'(gran);
  assign above_gran = (count > gran_ext);

  always_comb begin
    if (frame_en) begin
      alarm_d = 1'b0;
    end else if (alarm_q) begin
      alarm_d = above_gran;
    end else begin
      alarm_d = (count >= level) && above_gran;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_q <= 1'b0;
    end else begin
      alarm_q <= alarm_d;
    end
  end

  assign alarm = alarm_q;

  // R8
  frame_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_en |=> !alarm_q);

  // R10
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_q && (count <= gran_ext)) |=> !alarm_q);
endmodule

// File: rtl/rx_byte_queue.sv
module rx_byte_queue
  import rxq_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  input  logic [1:0]       reg_addr,
  input  logic             reg_we,
  input  logic [15:0]      reg_wdata,
  output logic [15:0]      reg_rdata,
  output logic             full_o,
  output logic             empty_o,
  output logic             alarm_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic              sync1_q, sync2_q;
  logic              rst_sync_n;
  logic [CNT_W-1:0]  count;
  logic              full, empty, alarm;
  rxq_events_t       events;
  logic              ovf, udf, err;
  logic              st_we, ct_we, lv_we;
  logic              frame_q, frame_d;
  logic [GRAN_W-1:0] gran_q, gran_d;
  logic [CNT_W-1:0]  level_q, level_d;
  logic              unused_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= 1'b1;
      sync2_q <= sync1_q;
    end
  end
  assign rst_sync_n = sync2_q;

  assign st_we = reg_we && (reg_addr == RA_STATUS);
  assign ct_we = reg_we && (reg_addr == RA_CTRL);
  assign lv_we = reg_we && (reg_addr == RA_LEVEL);

  always_comb begin
    frame_d = frame_q;
    gran_d  = gran_q;
    level_d = level_q;
    if (ct_we) begin
      frame_d = reg_wdata[CT_FRAME];
      gran_d  = reg_wdata[GRAN_W-1:0];
    end
    if (lv_we) begin
      level_d = reg_wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      frame_q <= 1'b1;
      gran_q  <= GRAN_W'(1);
      level_q <= '0;
    end else begin
      frame_q <= frame_d;
      gran_q  <= gran_d;
      level_q <= level_d;
    end
  end

  assign unused_wdata = ^{reg_wdata[15:CNT_W], reg_wdata[3:0]};

  rxq_storage #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .push_req  (wr_en),
    .push_data (wr_data),
    .pop_req   (rd_en),
    .pop_data  (rd_data),
    .count     (count),
    .full      (full),
    .empty     (empty),
    .events    (events)
  );

  rxq_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .events  (events),
    .clr_ovf (st_we & reg_wdata[ST_OVF]),
    .clr_udf (st_we & reg_wdata[ST_UDF]),
    .clr_err (st_we & reg_wdata[ST_ERR]),
    .ovf     (ovf),
    .udf     (udf),
    .err     (err)
  );

  rxq_alarm #(.CNT_W(CNT_W)) u_alarm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .count    (count),
    .level    (level_q),
    .gran     (gran_q),
    .frame_en (frame_q),
    .alarm    (alarm)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_STATUS: begin
        reg_rdata[ST_EMPTY] = empty;
        reg_rdata[ST_ALARM] = alarm;
        reg_rdata[ST_FULL]  = full;
        reg_rdata[ST_OVF]   = ovf;
        reg_rdata[ST_UDF]   = udf;
        reg_rdata[ST_ERR]   = err;
      end
      RA_CTRL: begin
        reg_rdata[CT_FRAME]     = frame_q;
        reg_rdata[GRAN_W-1:0]   = gran_q;
      end
      RA_LEVEL: reg_rdata[CNT_W-1:0] = level_q;
      default:  reg_rdata[CNT_W-1:0] = count;
    endcase
  end

  assign full_o  = full;
  assign empty_o = empty;
  assign alarm_o = alarm;

  // R6
  w1c_only_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_we && !reg_wdata[ST_OVF] && !events.ovf && ovf) |=> ovf);
endmodule

// File: tb/rx_byte_queue_tb.sv
module rx_byte_queue_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;
  logic [1:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        full_o, empty_o, alarm_o;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0] sb[$];
  logic chk_pend = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_byte_queue u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .full_o(full_o),
    .empty_o(empty_o), .alarm_o(alarm_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [15:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] v);
    reg_addr = a; reg_wdata = v; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic push(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    if (sb.size() < 16) sb.push_back(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pop();
    bit had = (sb.size() != 0);
    rd_en = 1'b1;
    @(posedge clk);
    if (had) chk_pend = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // monitor: compares each accepted pop against the scoreboard head (R1)
  always @(negedge clk) begin
    if (chk_pend) begin
      logic [7:0] e;
      e = sb.pop_front();
      chk_pend = 1'b0;
      check(rd_data == e, "R1 order", rd_data, e);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [7:0] last;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    rd_reg(2'd0, v); check(v == 16'h0001, "R2 reset status", v, 16'h0001);
    rd_reg(2'd1, v); check(v == 16'h0009, "R7 ctrl reset", v, 16'h0009);
    rd_reg(2'd2, v); check(v == 16'h0000, "R7 level reset", v, 0);
    rd_reg(2'd3, v); check(v == 16'h0000, "R2 count reset", v, 0);
    check(empty_o && !full_o && !alarm_o, "R2 reset pins", {empty_o, full_o, alarm_o}, 3'b100);

    // frame mode holds the request off
    push(8'h11); push(8'h22); push(8'h33);
    @(negedge clk);
    check(alarm_o == 1'b0, "R8 frame hold", alarm_o, 0);
    rd_reg(2'd3, v); check(v == 16'd3, "R2 count 3", v, 3);
    wr_reg(2'd1, 16'h0002);
    @(negedge clk);
    check(alarm_o == 1'b1, "R9 raise after frame cleared", alarm_o, 1);
    pop();
    @(negedge clk);
    check(alarm_o == 1'b0, "R10 release at gran", alarm_o, 0);
    pop(); pop();

    // hysteresis: level 5, release 2
    wr_reg(2'd2, 16'h0005);
    push(8'hA0); push(8'hA1); push(8'hA2); push(8'hA3);
    @(negedge clk);
    check(alarm_o == 1'b0, "R9 below level", alarm_o, 0);
    push(8'hA4);
    @(negedge clk);
    check(alarm_o == 1'b1, "R9 at level", alarm_o, 1);
    rd_reg(2'd0, v); check(v[1] == 1'b1, "R9 status alarm bit", v[1], 1);
    pop(); @(negedge clk);
    check(alarm_o == 1'b1, "R10 hold at 4", alarm_o, 1);
    pop(); @(negedge clk);
    check(alarm_o == 1'b1, "R10 hold at 3", alarm_o, 1);
    pop(); @(negedge clk);
    check(alarm_o == 1'b0, "R10 drop at 2", alarm_o, 0);
    pop(); pop();

    // fill to full, then one more push
    for (int i = 0; i < 16; i++) push(8'(8'h40 + i));
    rd_reg(2'd0, v); check(v[2] && !v[0] && full_o, "R2 full", v, 16'h0004);
    rd_reg(2'd3, v); check(v == 16'd16, "R2 count 16", v, 16);
    push(8'hEE);
    rd_reg(2'd3, v); check(v == 16'd16, "R3 count kept", v, 16);
    rd_reg(2'd0, v);
    check(v[4] == 1'b1, "R3 overflow flag", v[4], 1);
    check(v[6] == 1'b1, "R5 error on overflow", v[6], 1);
    check((v & 16'hFF88) == 16'h0, "R11 status reserved", v & 16'hFF88, 0);
    for (int i = 0; i < 16; i++) pop();
    @(negedge clk);
    rd_reg(2'd0, v); check(v[0] && empty_o, "R2 empty after drain", v, 1);
    last = rd_data;
    check(last == 8'h4F, "R1 last byte", last, 8'h4F);

    // clear overflow/error, then pop while empty
    wr_reg(2'd0, 16'h0050);
    rd_reg(2'd0, v); check(v == 16'h0001, "R6 w1c clears", v, 16'h0001);
    pop();
    check(rd_data == last, "R4 data held", rd_data, last);
    rd_reg(2'd3, v); check(v == 16'd0, "R4 count kept", v, 0);
    rd_reg(2'd0, v);
    check(v[5] == 1'b1, "R4 underflow flag", v[5], 1);
    check(v[6] == 1'b1, "R5 error on underflow", v[6], 1);
    check(v[4] == 1'b0, "R6 overflow stays clear", v[4], 0);

    // writes of zeros and to live bits change nothing
    wr_reg(2'd0, 16'h0007);
    rd_reg(2'd0, v); check(v == 16'h0061, "R6 live bits ignored", v, 16'h0061);
    wr_reg(2'd0, 16'h0020);
    rd_reg(2'd0, v); check(v == 16'h0041, "R6 only underflow cleared", v, 16'h0041);
    wr_reg(2'd0, 16'h0040);
    rd_reg(2'd0, v); check(v == 16'h0001, "R6 error cleared", v, 16'h0001);

    // reserved bits in control and level
    wr_reg(2'd1, 16'hFFF0);
    rd_reg(2'd1, v); check(v == 16'h0000, "R11 ctrl reserved", v, 0);
    wr_reg(2'd2, 16'hFFFF);
    rd_reg(2'd2, v); check(v == 16'h001F, "R11 level reserved", v, 16'h001F);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule